// File: doc/BRIEF.md
# Delta-Sigma ADC Scan Sequencer

This block is a synchronous controller for an external 24-bit delta-sigma converter. The converter sits on a four-wire serial link, with a separate conversion-start pin and an active-low data-ready pin. After reset, the controller brings the converter up in a fixed, timed order. It holds chip select and the start pin low for a short settling interval. It then issues the converter's reset command and waits a long recovery window. Next it writes five configuration registers, one frame each, and finally sends a start-conversion command.

Once the converter is running, the controller scans the analog input pairs without ever stopping it. It waits for data-ready to fall and shifts out one signed conversion word. It presents that word with the index of the channel it came from. It then rewrites only the input-multiplexer register to select the next pair. Because that write restarts conversion by itself, no stop or start command is needed between channels. If data-ready never falls within a parameterised window, the controller flags a timeout and restarts the scan at channel 0.

Top module: `adc_scan_seq`

## Requirements
- R1: While reset is held, `cs_n` is 1, `sclk` is 0, and `res_valid` and `timeout` are 0. After reset is released, `cs_n` drops to 0 and stays there, and `adc_start` is always 0. The first SCLK rising edge comes at least PRE_WAIT (2) clock cycles after `cs_n` falls.
- R2: The first frame is the single byte 0x06 (reset command). The next SCLK rising edge comes at least RESET_WAIT (4096) cycles after that byte's last falling edge.
- R3: Configuration then follows as five three-byte write frames, in this order: 0x49 0x00 0x00 (status, address 9), 0x43 0x00 0xEF (gain/delay, address 3), 0x44 0x00 0x5B (data rate, address 4), 0x45 0x00 0x10 (reference, address 5), and 0x42 0x00 0x01 (multiplexer, address 2). Each frame is the opcode 0x40 ORed with the address, then a count byte of 0x00, then the value.
- R4: Between the last SCLK fall of one frame and the first SCLK rise of the next, at least FRAME_GAP (1) full idle cycle passes.
- R5: After configuration, the single byte 0x08 (start command) is sent. A result read begins no sooner than START_WAIT (4) cycles after that byte ends.
- R6: SCLK idles low and has a period of SCLK_DIV (4) clock cycles, with bits sent back to back inside a frame. MOSI changes only when SCLK rises, and MISO is sampled when SCLK falls. All bytes go MSB first.
- R7: A read starts only while `drdy_n` is 0. It gives exactly RES_W (24) SCLK pulses with MOSI held at 0. While `drdy_n` stays 1, no SCLK activity takes place.
- R8: Each read ends with a one-cycle `res_valid` pulse. At that pulse, `res_data` holds the bits received, first bit in the MSB, and `res_ch` holds the index of the channel that was converted.
- R9: After each result, the controller writes the multiplexer frame 0x42 0x00 code for the next channel, where code = {4-bit 2k, 4-bit 2k+1} for channel k. Channels count up and wrap from NUM_CH-1 to 0. No start or stop byte is sent between channels.
- R10: If `drdy_n` stays 1 for DRDY_TIMEOUT cycles after a frame, `timeout` pulses for one cycle, about DRDY_TIMEOUT cycles after the last SCLK fall. The next frame is the channel-0 multiplexer write (0x42 0x00 0x01), and the next result is tagged channel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| drdy_n | input | 1 | Converter data-ready, active low |
| miso | input | 1 | Serial data from converter |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to converter |
| adc_start | output | 1 | Conversion-start pin, held low |
| res_data | output | RES_W | Conversion result, two's complement |
| res_ch | output | CH_W | Channel index of the result |
| res_valid | output | 1 | One-cycle result strobe |
| timeout | output | 1 | One-cycle pulse when data-ready never arrives |

## Verification
The assertions watch several rules on every cycle. They check that MOSI moves only when SCLK rises and that SCLK stays low outside a transfer. They check that chip select never rises again once the scan begins, and that a read is entered only from a cycle that saw data-ready low. They also check that the result strobe and the timeout pulse last a single cycle, and that the channel index stays in range, wraps and resets on timeout. The scenarios in the bench cover what no single-cycle property can show. These are the exact byte stream of the bring-up and of each multiplexer rewrite, and the minimum intervals between frames. They also cover bit order and sampling of the returned words, the absence of clocking while data-ready stays high, and the timing and effect of a timeout.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   localparam logic [7:0] OP_RESET = 8'h06;
   localparam logic [7:0] OP_START = 8'h08;
   localparam logic [7:0] OP_WREG  = 8'h40;

   localparam logic [3:0] ADR_MUX  = 4'h2;
   localparam logic [3:0] ADR_GAIN = 4'h3;
   localparam logic [3:0] ADR_RATE = 4'h4;
   localparam logic [3:0] ADR_REF  = 4'h5;
   localparam logic [3:0] ADR_STAT = 4'h9;

   localparam int CFG_LAST = 4;

   typedef enum logic [3:0] {
      ST_BOOT, ST_PRE, ST_TX_RST, ST_RWAIT, ST_TX_CFG, ST_CGAP, ST_SGAP,
      ST_TX_START, ST_SWAIT, ST_POLL, ST_RD, ST_MGAP, ST_TX_MUX
   } seq_state_t;

   function automatic logic [23:0] wreg_frame(input logic [3:0] adr, input logic [7:0] val);
      return {OP_WREG | {4'h0, adr}, 8'h00, val};
   endfunction

endpackage

// File: rtl/adc_spi_xfer.sv
module adc_spi_xfer #(
   parameter int DIV  = 4,
   parameter int MAXB = 24,
   localparam int PW  = $clog2(DIV),
   localparam int BW  = $clog2(MAXB + 1),
   localparam int HALF = DIV / 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            go,
   input  logic [BW-1:0]   nbits,
   input  logic [MAXB-1:0] tx,
   input  logic            miso,
   output logic            sclk,
   output logic            mosi,
   output logic            busy,
   output logic            done,
   output logic [MAXB-1:0] rx
);

   logic [PW-1:0]   ph;
   logic [BW-1:0]   left;
   logic [MAXB-1:0] sh_tx;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         sclk  <= 1'b0;
         mosi  <= 1'b0;
         ph    <= '0;
         left  <= '0;
         sh_tx <= '0;
         rx    <= '0;
      end else begin
         done <= 1'b0;
         if (go && !busy) begin
            busy  <= 1'b1;
            ph    <= '0;
            left  <= nbits;
            sh_tx <= tx;
            rx    <= '0;
         end else if (busy) begin
            ph <= (ph == PW'(DIV - 1)) ? '0 : ph + 1'b1;
            if (ph == '0) begin
               sclk  <= 1'b1;
               mosi  <= sh_tx[MAXB-1];
               sh_tx <= {sh_tx[MAXB-2:0], 1'b0};
            end else if (ph == PW'(HALF)) begin
               sclk <= 1'b0;
               rx   <= {rx[MAXB-2:0], miso};
               left <= left - 1'b1;
               if (left == BW'(1)) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end
            end
         end
      end
   end

   // R6
   mosi_edge_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(mosi) |-> $rose(sclk));

   // R6
   sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !busy |-> !sclk);

endmodule

// File: rtl/adc_seq_delay.sv
module adc_seq_delay #(
   parameter int W = 13
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         expired
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (load)        cnt <= val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   // R4
   cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/adc_seq_chan.sv
module adc_seq_chan #(
   parameter int NUM_CH = 3,
   parameter int CH_W   = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            adv,
   input  logic            restart,
   output logic [CH_W-1:0] ch,
   output logic [7:0]      mux_code
);

   logic [3:0] pos;

   always_ff @(posedge clk) begin
      if (rst || restart)  ch <= '0;
      else if (adv)        ch <= (ch == CH_W'(NUM_CH - 1)) ? '0 : ch + 1'b1;
   end

   assign pos      = 4'(ch) << 1;
   assign mux_code = {pos, pos | 4'd1};

   // R9
   ch_range_chk: assert property (@(posedge clk) disable iff (rst)
      int'(ch) < NUM_CH);

   // R9
   ch_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (adv && !restart && int'(ch) == NUM_CH - 1) |=> (ch == '0));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import adc_seq_pkg::*;
#(
   parameter int SCLK_DIV     = 4,
   parameter int NUM_CH       = 3,
   parameter int CH_W         = 3,
   parameter int RES_W        = 24,
   parameter int PRE_WAIT     = 2,
   parameter int RESET_WAIT   = 4096,
   parameter int FRAME_GAP    = 1,
   parameter int START_WAIT   = 4,
   parameter int DRDY_TIMEOUT = 1000000,
   parameter logic [7:0] CFG_STAT = 8'h00,
   parameter logic [7:0] CFG_GAIN = 8'hEF,
   parameter logic [7:0] CFG_RATE = 8'h5B,
   parameter logic [7:0] CFG_REF  = 8'h10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             drdy_n,
   input  logic             miso,
   output logic             cs_n,
   output logic             sclk,
   output logic             mosi,
   output logic             adc_start,
   output logic [RES_W-1:0] res_data,
   output logic [CH_W-1:0]  res_ch,
   output logic             res_valid,
   output logic             timeout
);

   localparam int XW   = 24;
   localparam int BW   = $clog2(XW + 1);
   localparam int M0   = (RESET_WAIT > DRDY_TIMEOUT) ? RESET_WAIT : DRDY_TIMEOUT;
   localparam int M1   = (PRE_WAIT > START_WAIT) ? PRE_WAIT : START_WAIT;
   localparam int M2   = (M1 > FRAME_GAP) ? M1 : FRAME_GAP;
   localparam int WMAX = (M0 > M2) ? M0 : M2;
   localparam int TW   = $clog2(WMAX + 1);

   if (SCLK_DIV < 2 || (SCLK_DIV % 2) != 0)
      $error("SCLK_DIV must be an even value of at least 2");
   if (NUM_CH < 1 || NUM_CH > 8 || NUM_CH > (1 << CH_W))
      $error("NUM_CH must fit both CH_W and eight input pairs");
   if (RES_W < 8 || RES_W > XW)
      $error("RES_W must lie between 8 and 24");
   if (PRE_WAIT < 1 || FRAME_GAP < 1 || START_WAIT < 1 || DRDY_TIMEOUT < 1)
      $error("wait lengths must be at least one cycle");

   seq_state_t st, nxt;
   logic [2:0]  cfg_idx;
   logic        go, busy, done, ld, tmr_exp, adv, rs, to_hit;
   logic [BW-1:0] nb;
   logic [XW-1:0] txw, rx;
   logic [TW-1:0] ldv;
   logic [CH_W-1:0] ch;
   logic [7:0]  mux_code;
   logic [23:0] cfg_word;

   adc_spi_xfer #(.DIV(SCLK_DIV), .MAXB(XW)) u_xfer (
      .clk(clk), .rst(rst), .go(go), .nbits(nb), .tx(txw), .miso(miso),
      .sclk(sclk), .mosi(mosi), .busy(busy), .done(done), .rx(rx));

   adc_seq_delay #(.W(TW)) u_delay (
      .clk(clk), .rst(rst), .load(ld), .val(ldv), .expired(tmr_exp));

   adc_seq_chan #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chan (
      .clk(clk), .rst(rst), .adv(adv), .restart(rs), .ch(ch), .mux_code(mux_code));

   always_comb begin
      case (cfg_idx)
         3'd0:    cfg_word = wreg_frame(ADR_STAT, CFG_STAT);
         3'd1:    cfg_word = wreg_frame(ADR_GAIN, CFG_GAIN);
         3'd2:    cfg_word = wreg_frame(ADR_RATE, CFG_RATE);
         3'd3:    cfg_word = wreg_frame(ADR_REF,  CFG_REF);
         default: cfg_word = wreg_frame(ADR_MUX,  mux_code);
      endcase
   end

   always_comb begin
      nxt    = st;
      go     = 1'b0;
      nb     = BW'(8);
      txw    = '0;
      ld     = 1'b0;
      ldv    = '0;
      adv    = 1'b0;
      rs     = 1'b0;
      to_hit = 1'b0;
      case (st)
         ST_BOOT: begin
            ld = 1'b1; ldv = TW'(PRE_WAIT); nxt = ST_PRE;
         end
         ST_PRE: if (tmr_exp) begin
            go = 1'b1; txw = XW'(OP_RESET) << (XW - 8); nxt = ST_TX_RST;
         end
         ST_TX_RST: if (done) begin
            ld = 1'b1; ldv = TW'(RESET_WAIT); nxt = ST_RWAIT;
         end
         ST_RWAIT, ST_CGAP: if (tmr_exp) begin
            go = 1'b1; nb = BW'(24); txw = cfg_word; nxt = ST_TX_CFG;
         end
         ST_TX_CFG: if (done) begin
            ld = 1'b1; ldv = TW'(FRAME_GAP);
            nxt = (cfg_idx == 3'(CFG_LAST)) ? ST_SGAP : ST_CGAP;
         end
         ST_SGAP: if (tmr_exp) begin
            go = 1'b1; txw = XW'(OP_START) << (XW - 8); nxt = ST_TX_START;
         end
         ST_TX_START: if (done) begin
            ld = 1'b1; ldv = TW'(START_WAIT); nxt = ST_SWAIT;
         end
         ST_SWAIT: if (tmr_exp) begin
            ld = 1'b1; ldv = TW'(DRDY_TIMEOUT); nxt = ST_POLL;
         end
         ST_POLL: begin
            if (!drdy_n) begin
               go = 1'b1; nb = BW'(RES_W); nxt = ST_RD;
            end else if (tmr_exp) begin
               to_hit = 1'b1; rs = 1'b1;
               ld = 1'b1; ldv = TW'(FRAME_GAP); nxt = ST_MGAP;
            end
         end
         ST_RD: if (done) begin
            adv = 1'b1; ld = 1'b1; ldv = TW'(FRAME_GAP); nxt = ST_MGAP;
         end
         ST_MGAP: if (tmr_exp) begin
            go = 1'b1; nb = BW'(24); txw = wreg_frame(ADR_MUX, mux_code); nxt = ST_TX_MUX;
         end
         ST_TX_MUX: if (done) begin
            ld = 1'b1; ldv = TW'(DRDY_TIMEOUT); nxt = ST_POLL;
         end
         default: nxt = ST_BOOT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st        <= ST_BOOT;
         cfg_idx   <= '0;
         cs_n      <= 1'b1;
         adc_start <= 1'b0;
         res_data  <= '0;
         res_ch    <= '0;
         res_valid <= 1'b0;
         timeout   <= 1'b0;
      end else begin
         st        <= nxt;
         cs_n      <= 1'b0;
         adc_start <= 1'b0;
         res_valid <= 1'b0;
         timeout   <= to_hit;
         if (st == ST_TX_CFG && done && cfg_idx != 3'(CFG_LAST))
            cfg_idx <= cfg_idx + 1'b1;
         if (st == ST_RD && done) begin
            res_data  <= rx[RES_W-1:0];
            res_ch    <= ch;
            res_valid <= 1'b1;
         end
      end
   end

   // R1
   cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !cs_n |=> !cs_n);

   // R7
   read_gate_chk: assert property (@(posedge clk) disable iff (rst)
      (st == ST_RD && $past(st) == ST_POLL) |-> !$past(drdy_n));

   // R8
   valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      res_valid |=> !res_valid);

   // R8
   valid_ch_chk: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> int'(res_ch) < NUM_CH);

   // R10
   timeout_restart_chk: assert property (@(posedge clk) disable iff (rst)
      timeout |-> (ch == '0 && !res_valid));

   // R10
   timeout_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      timeout |=> !timeout);

endmodule

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;

   localparam int TO = 2000;
   localparam int NCH = 3;
   localparam logic [7:0] BRING [17] = '{8'h06, 8'h49, 8'h00, 8'h00, 8'h43, 8'h00, 8'hEF,
                                        8'h44, 8'h00, 8'h5B, 8'h45, 8'h00, 8'h10,
                                        8'h42, 8'h00, 8'h01, 8'h08};
   localparam logic [23:0] SAMPLES [8] = '{24'h7FFFFF, 24'h800000, 24'h123456, 24'hFFFFFF,
                                          24'h000001, 24'hA5A5A5, 24'h000000, 24'h5A5A5A};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic miso = 1'b0;
   logic drdy_n;
   logic cs_n, sclk, mosi, adc_start, res_valid, timeout;
   logic [23:0] res_data;
   logic [2:0]  res_ch;

   always #10 clk = ~clk;

   adc_scan_seq #(.DRDY_TIMEOUT(TO)) uut (
      .clk(clk), .rst(rst), .drdy_n(drdy_n), .miso(miso), .cs_n(cs_n), .sclk(sclk),
      .mosi(mosi), .adc_start(adc_start), .res_data(res_data), .res_ch(res_ch),
      .res_valid(res_valid), .timeout(timeout));

   int checks = 0, errors = 0, cyc = 0;
   logic [7:0] bytes_q [0:255];
   int t_rise [0:255];
   int t_fall [0:255];
   int nbytes = 0, nbits = 0, t_cs = -1, t_first = -1, n_to = 0;
   logic [7:0] cur = '0;
   logic sclk_q = 1'b0, start_hi = 1'b0, finished = 1'b0;
   int req_id = 0, done_id = 0, rd_rise = 0;
   logic [23:0] rd_word = '0;

   assign drdy_n = !((req_id != done_id) && rd_rise == 0);

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   function automatic logic [7:0] mcode(input int k);
      return {4'(2 * k), 4'(2 * k + 1)};
   endfunction

   always @(negedge clk) begin
      cyc++;
      if (!rst && !cs_n && t_cs < 0) t_cs = cyc;
      if (!rst && adc_start) start_hi = 1'b1;
      if (timeout) n_to++;
      if (sclk && !sclk_q) begin
         if (nbits == 0 && nbytes < 256) t_rise[nbytes] = cyc;
         if (t_first < 0) t_first = cyc;
         if (req_id != done_id) begin
            miso = rd_word[23 - rd_rise];
            rd_rise++;
         end
      end
      if (!sclk && sclk_q) begin
         cur = {cur[6:0], mosi};
         nbits++;
         if (nbits == 8) begin
            if (nbytes < 256) begin
               bytes_q[nbytes] = cur;
               t_fall[nbytes] = cyc;
            end
            nbytes++;
            nbits = 0;
         end
         if (req_id != done_id && rd_rise == 24) begin
            done_id = req_id;
            rd_rise = 0;
         end
      end
      sclk_q = sclk;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         report();
      end
   end

   task automatic wait_bytes(input int n, input int lim, input string req);
      int k = 0;
      while (nbytes < n && k < lim) begin
         @(negedge clk);
         k++;
      end
      chk(nbytes >= n, req, nbytes, n);
   endtask

   task automatic wait_valid(input int lim, input string req);
      int k = 0;
      while (!res_valid && k < lim) begin
         @(negedge clk);
         k++;
      end
      chk(res_valid, req, res_valid, 1);
   endtask

   initial begin
      int base, n0, tmux, tt;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(cs_n && !sclk && !res_valid && !timeout, "R1 reset",
          {cs_n, sclk, res_valid, timeout}, 4'b1000);
      rst = 1'b0;

      wait_bytes(17, 20000, "R3 bring-up");
      for (int i = 0; i < 17; i++)
         chk(bytes_q[i] == BRING[i], (i == 0) ? "R2 reset cmd" : (i == 16) ? "R5 start cmd" : "R3 cfg",
             bytes_q[i], BRING[i]);
      // R1 settle before first clock
      chk(t_first - t_cs >= 2, "R1 pre-wait", t_first - t_cs, 2);
      // R2 recovery window
      chk(t_rise[1] - t_fall[0] >= 4096, "R2 wait", t_rise[1] - t_fall[0], 4096);
      // R4 gaps between configuration frames
      for (int k = 4; k <= 16; k += 3)
         chk(t_rise[k] - t_fall[k-1] >= 2, "R4 gap", t_rise[k] - t_fall[k-1], 2);
      // R6 byte spacing inside a frame = 8 bits * 4 cycles
      chk(t_rise[2] - t_rise[1] == 32, "R6 rate", t_rise[2] - t_rise[1], 32);

      for (int p = 0; p < 8; p++) begin
         base = nbytes;
         rd_word = SAMPLES[p];
         req_id++;
         wait_valid(2000, "R8 valid");
         // R8 data and channel tag
         chk(res_data == SAMPLES[p], "R8 data", res_data, SAMPLES[p]);
         chk(int'(res_ch) == p % NCH, "R9 channel", res_ch, p % NCH);
         @(negedge clk);
         chk(!res_valid, "R8 pulse", res_valid, 0);
         if (p == 0)
            chk(t_rise[17] - t_fall[16] >= 5, "R5 start wait", t_rise[17] - t_fall[16], 5);
         wait_bytes(base + 6, 2000, "R9 mux write");
         // R7 read clocks MOSI zero
         for (int j = 0; j < 3; j++)
            chk(bytes_q[base + j] == 8'h00, "R7 mosi", bytes_q[base + j], 0);
         // R9 next channel multiplexer frame
         chk(bytes_q[base + 3] == 8'h42, "R9 opcode", bytes_q[base + 3], 8'h42);
         chk(bytes_q[base + 4] == 8'h00, "R9 count", bytes_q[base + 4], 0);
         chk(bytes_q[base + 5] == mcode((p + 1) % NCH), "R9 code",
             bytes_q[base + 5], mcode((p + 1) % NCH));
         chk(t_rise[base + 3] - t_fall[base + 2] >= 2, "R4 gap", t_rise[base + 3] - t_fall[base + 2], 2);
         n0 = nbytes;
         repeat (40) @(negedge clk);
         // R7 no clocking while data-ready high
         chk(nbytes == n0 && nbits == 0 && !sclk, "R7 idle", nbytes, n0);
      end
      chk(n_to == 0, "R10 no early timeout", n_to, 0);

      tmux = t_fall[nbytes - 1];
      base = nbytes;
      tt = 0;
      for (int k = 0; k < TO + 200 && !timeout; k++) @(negedge clk);
      tt = cyc;
      chk(timeout, "R10 pulse", timeout, 1);
      chk(tt - tmux >= TO && tt - tmux <= TO + 10, "R10 time", tt - tmux, TO);
      @(negedge clk);
      chk(!timeout, "R10 width", timeout, 0);
      wait_bytes(base + 3, 2000, "R10 mux");
      chk(bytes_q[base] == 8'h42 && bytes_q[base + 1] == 8'h00 && bytes_q[base + 2] == 8'h01,
          "R10 restart frame", {bytes_q[base], bytes_q[base + 1], bytes_q[base + 2]}, 24'h420001);
      rd_word = 24'h3C3C3C;
      req_id++;
      wait_valid(2000, "R10 read");
      chk(res_ch == 3'd0, "R10 channel", res_ch, 0);
      chk(res_data == 24'h3C3C3C, "R8 data", res_data, 24'h3C3C3C);
      // R1 start pin and chip select
      chk(!start_hi && !cs_n, "R1 pins", {start_hi, cs_n}, 0);
      report();
   end

endmodule